// File: doc/BRIEF.md
# HDTV Output Source Selector with Test Patterns

This block sits in the pixel path of a high-definition video encoder, just before the output stage. On every clock it picks one of four sources for the three 10-bit colour components: forced black, the incoming YCrCb pixel, a cross-hatch pattern, or a uniform colour field. It uses the timing information that the upstream sync logic supplies: an active-picture flag, a vertical-blanking flag, the current line number, the zero-based active line and column, and a frame-start pulse. It also uses a data-valid strobe whose polarity can be selected.

Several mode inputs control the selection: output enable, pattern enable, solid-versus-hatch, blanking-data pass, 720p-versus-1080i and valid polarity. There are also three programmable colour registers for the pattern. Mode and colour changes are staged. They take effect only on the frame-start edge, so a frame never shows a mix of two settings. During vertical blanking, input data may pass through only on a line window that depends on the standard. Everywhere else outside the picture the output is black.

Top module: `hdtv_pattern_blank`

## Requirements
- R1: When the active output-enable setting is 0, every output is black (Y=64, Cr=512, Cb=512). This holds whatever the input pixel is, whether the pattern is enabled, and on blanking lines as well.
- R2: With output enabled and pattern disabled, an active-picture pixel whose valid strobe is qualified appears on the outputs unchanged. An unqualified one is output as black.
- R3: With output and pattern enabled and solid mode selected (select=1), every active-picture pixel is output as the current pattern colour.
- R4: In hatch mode (select=0), an active pixel is output in the pattern colour when its column is a multiple of 64 or its active line is a multiple of 64, both counted from zero. Every other active pixel is black.
- R5: After reset the pattern colour registers hold white (Y=940, Cr=512, Cb=512). A write strobe loads new values into them.
- R6: With blanking-data pass enabled and 1080i selected (standard bit 0), a vertical-blanking input pixel with a qualified valid strobe passes through only on line numbers 7 to 20 inclusive. All other blanking lines are black.
- R7: With 720p selected (standard bit 1), the pass window is lines 6 to 25 inclusive. With blanking-data pass disabled, every vertical-blanking line is black.
- R8: Valid polarity bit 0 qualifies a pixel when the strobe is 1. Polarity bit 1 qualifies a pixel when the strobe is 0.
- R9: Mode inputs and colour writes have no effect on the output until the clock edge at which frame start is high. From the next cycle on, the new settings apply. A colour write on that same edge waits for the following frame start.
- R10: The outputs are registered with exactly one cycle of latency. Outside the active picture and the allowed blanking window, the output is black whatever the pattern setting.
- R11: During and right after reset, the outputs are black and all active mode settings are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame or field |
| act_de | input | 1 | High inside the active picture |
| vblank | input | 1 | High on vertical-blanking lines |
| line_num | input | 11 | Current line number within the frame or field |
| act_line | input | 11 | Active line index, counted from zero |
| act_col | input | 12 | Active pixel column, counted from zero |
| dv | input | 1 | Input data-valid strobe |
| in_y | input | 10 | Input luma |
| in_cr | input | 10 | Input red-difference chroma |
| in_cb | input | 10 | Input blue-difference chroma |
| m_pix_en | input | 1 | Output enable (staged) |
| m_pat_en | input | 1 | Pattern enable (staged) |
| m_pat_solid | input | 1 | 0 hatch, 1 solid field (staged) |
| m_vbi_open | input | 1 | Allow data on blanking window lines (staged) |
| m_std_720p | input | 1 | 0 1080i, 1 720p (staged) |
| m_dv_low | input | 1 | Valid strobe polarity, 1 means active low (staged) |
| col_we | input | 1 | Pattern colour write strobe |
| col_y_wr | input | 10 | Pattern luma to write |
| col_cr_wr | input | 10 | Pattern Cr to write |
| col_cb_wr | input | 10 | Pattern Cb to write |
| out_y | output | 10 | Selected luma |
| out_cr | output | 10 | Selected Cr |
| out_cb | output | 10 | Selected Cb |

## Verification
The hardest case to reach from the ports is a setting that has been presented but is not yet active. This covers a mode input that changes in the middle of a frame, and a colour write that lands after the last frame start or on the same edge as one. In these cases the output must keep showing the old settings. The stimulus drives such changes without a frame-start pulse and samples several active pixels before it issues the pulse. It also places a colour write on a frame-start edge. The blanking window is covered by walking line numbers across both ends of each standard's window, one line inside and one line outside.

// File: rtl/vidsel_pkg.sv
// Package: shared mode type and colour code constants for the output
// source selector. Assumes 10-bit component codes.
package vidsel_pkg;

    // Staged mode bits, captured together at frame start.
    typedef struct packed {
        logic pix_en;
        logic pat_en;
        logic pat_solid;
        logic vbi_open;
        logic std_720p;
        logic dv_low;
    } mode_t;

    localparam int BLACK_Y10 = 64;
    localparam int NEUTRAL_C10 = 512;
    localparam int WHITE_Y10 = 940;

    // Blanking-data line windows per standard (inclusive bounds).
    localparam int WIN_1080I_LO = 7;
    localparam int WIN_1080I_HI = 20;
    localparam int WIN_720P_LO = 6;
    localparam int WIN_720P_HI = 25;

endpackage

// File: rtl/mode_shadow.sv
// Module: mode_shadow
// Holds the pattern colour staging registers and the active copies of
// mode and colour, which load only on the frame-start edge.
// Assumes frame_start is a single-cycle pulse from the timing logic.
module mode_shadow
    import vidsel_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  mode_t         mode_in,
    input  logic          col_we,
    input  logic [DW-1:0] wr_y,
    input  logic [DW-1:0] wr_cr,
    input  logic [DW-1:0] wr_cb,
    output mode_t         mode_cur,
    output logic [DW-1:0] cur_y,
    output logic [DW-1:0] cur_cr,
    output logic [DW-1:0] cur_cb
);
    localparam logic [DW-1:0] WHT_Y = DW'(WHITE_Y10);
    localparam logic [DW-1:0] NEU_C = DW'(NEUTRAL_C10);

    logic [DW-1:0] stg_y, stg_cr, stg_cb;

    // Staging colour registers: written by the colour strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_y  <= WHT_Y;
            stg_cr <= NEU_C;
            stg_cb <= NEU_C;
        end else if (col_we) begin
            stg_y  <= wr_y;
            stg_cr <= wr_cr;
            stg_cb <= wr_cb;
        end
    end

    // Active copies: refreshed only at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_cur <= '0;
            cur_y    <= WHT_Y;
            cur_cr   <= NEU_C;
            cur_cb   <= NEU_C;
        end else if (frame_start) begin
            mode_cur <= mode_in;
            cur_y    <= stg_y;
            cur_cr   <= stg_cr;
            cur_cb   <= stg_cb;
        end
    end

    // R9: active settings never move outside a frame-start edge.
    a_r9_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(mode_cur) && $stable(cur_y) && $stable(cur_cr) && $stable(cur_cb)))
        else $error("a_r9_hold_mid_frame");

    // R5: staged colour only changes on a write strobe.
    a_r5_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !col_we |=> ($stable(stg_y) && $stable(stg_cr) && $stable(stg_cb)))
        else $error("a_r5_stage_hold");

endmodule

// File: rtl/vbi_window.sv
// Module: vbi_window
// Decides whether the current line number lies inside the blanking-data
// window of the selected standard, gated by the blanking-data enable.
// Assumes line_num is the frame/field line count from the timing logic.
module vbi_window
    import vidsel_pkg::*;
#(
    parameter int LW = 11
) (
    input  logic [LW-1:0] line_num,
    input  logic          std_720p,
    input  logic          vbi_open,
    output logic          vbi_ok
);
    localparam logic [LW-1:0] LO_I = LW'(WIN_1080I_LO);
    localparam logic [LW-1:0] HI_I = LW'(WIN_1080I_HI);
    localparam logic [LW-1:0] LO_P = LW'(WIN_720P_LO);
    localparam logic [LW-1:0] HI_P = LW'(WIN_720P_HI);

    logic in_i, in_p;

    // Window compare for both standards, then pick by standard.
    always_comb begin
        in_i   = (line_num >= LO_I) && (line_num <= HI_I);
        in_p   = (line_num >= LO_P) && (line_num <= HI_P);
        vbi_ok = vbi_open && (std_720p ? in_p : in_i);
    end

endmodule

// File: rtl/pattern_gen.sv
// Module: pattern_gen
// Produces the test pattern pixel: the programmed colour everywhere in
// solid mode, or on grid lines every 2**HATCH_LOG2 columns/lines in hatch
// mode with black between. Assumes zero-based active coordinates.
module pattern_gen
    import vidsel_pkg::*;
#(
    parameter int DW         = 10,
    parameter int LW         = 11,
    parameter int CW         = 12,
    parameter int HATCH_LOG2 = 6
) (
    input  logic [CW-1:0] act_col,
    input  logic [LW-1:0] act_line,
    input  logic          solid,
    input  logic [DW-1:0] c_y,
    input  logic [DW-1:0] c_cr,
    input  logic [DW-1:0] c_cb,
    output logic [DW-1:0] p_y,
    output logic [DW-1:0] p_cr,
    output logic [DW-1:0] p_cb
);
    localparam logic [CW-1:0] COL_MASK = CW'((1 << HATCH_LOG2) - 1);
    localparam logic [LW-1:0] LIN_MASK = LW'((1 << HATCH_LOG2) - 1);
    localparam logic [DW-1:0] BLK_Y = DW'(BLACK_Y10);
    localparam logic [DW-1:0] BLK_C = DW'(NEUTRAL_C10);

    logic on_grid;

    // Grid hit test and colour choice.
    always_comb begin
        on_grid = ((act_col & COL_MASK) == '0) || ((act_line & LIN_MASK) == '0);
        if (solid || on_grid) begin
            p_y  = c_y;
            p_cr = c_cr;
            p_cb = c_cb;
        end else begin
            p_y  = BLK_Y;
            p_cr = BLK_C;
            p_cb = BLK_C;
        end
    end

endmodule

// File: rtl/hdtv_pattern_blank.sv
// Module: hdtv_pattern_blank
// Output source selector for an HDTV encoder pixel path: black, live
// input, cross-hatch or solid colour, with blanking-data pass on a
// standard-dependent line window. One registered cycle of latency.
// Assumes timing inputs are aligned with the pixel data they describe.
module hdtv_pattern_blank
    import vidsel_pkg::*;
#(
    parameter int DW         = 10,
    parameter int LW         = 11,
    parameter int CW         = 12,
    parameter int HATCH_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          act_de,
    input  logic          vblank,
    input  logic [LW-1:0] line_num,
    input  logic [LW-1:0] act_line,
    input  logic [CW-1:0] act_col,
    input  logic          dv,
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_cr,
    input  logic [DW-1:0] in_cb,
    input  logic          m_pix_en,
    input  logic          m_pat_en,
    input  logic          m_pat_solid,
    input  logic          m_vbi_open,
    input  logic          m_std_720p,
    input  logic          m_dv_low,
    input  logic          col_we,
    input  logic [DW-1:0] col_y_wr,
    input  logic [DW-1:0] col_cr_wr,
    input  logic [DW-1:0] col_cb_wr,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_cr,
    output logic [DW-1:0] out_cb
);
    localparam logic [DW-1:0] BLK_Y = DW'(BLACK_Y10);
    localparam logic [DW-1:0] BLK_C = DW'(NEUTRAL_C10);

    mode_t         mode_in, mode_cur;
    logic [DW-1:0] cy, ccr, ccb;
    logic [DW-1:0] py, pcr, pcb;
    logic          vbi_ok, qual;
    logic [DW-1:0] nx_y, nx_cr, nx_cb;

    // Pack the raw mode inputs for staging.
    always_comb begin
        mode_in.pix_en    = m_pix_en;
        mode_in.pat_en    = m_pat_en;
        mode_in.pat_solid = m_pat_solid;
        mode_in.vbi_open  = m_vbi_open;
        mode_in.std_720p  = m_std_720p;
        mode_in.dv_low    = m_dv_low;
    end

    mode_shadow #(.DW(DW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .mode_in(mode_in), .col_we(col_we),
        .wr_y(col_y_wr), .wr_cr(col_cr_wr), .wr_cb(col_cb_wr),
        .mode_cur(mode_cur), .cur_y(cy), .cur_cr(ccr), .cur_cb(ccb)
    );

    vbi_window #(.LW(LW)) u_vbi (
        .line_num(line_num), .std_720p(mode_cur.std_720p),
        .vbi_open(mode_cur.vbi_open), .vbi_ok(vbi_ok)
    );

    pattern_gen #(.DW(DW), .LW(LW), .CW(CW), .HATCH_LOG2(HATCH_LOG2)) u_pat (
        .act_col(act_col), .act_line(act_line), .solid(mode_cur.pat_solid),
        .c_y(cy), .c_cr(ccr), .c_cb(ccb),
        .p_y(py), .p_cr(pcr), .p_cb(pcb)
    );

    // Source selection for the next output sample.
    always_comb begin
        qual  = dv ^ mode_cur.dv_low;
        nx_y  = BLK_Y;
        nx_cr = BLK_C;
        nx_cb = BLK_C;
        if (mode_cur.pix_en) begin
            if (act_de) begin
                if (mode_cur.pat_en) begin
                    nx_y = py; nx_cr = pcr; nx_cb = pcb;
                end else if (qual) begin
                    nx_y = in_y; nx_cr = in_cr; nx_cb = in_cb;
                end
            end else if (vblank && vbi_ok && qual) begin
                nx_y = in_y; nx_cr = in_cr; nx_cb = in_cb;
            end
        end
    end

    // Output register: one cycle of latency, black in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_y  <= BLK_Y;
            out_cr <= BLK_C;
            out_cb <= BLK_C;
        end else begin
            out_y  <= nx_y;
            out_cr <= nx_cr;
            out_cb <= nx_cb;
        end
    end

    // R1: output disabled means black on the next cycle.
    a_r1_disabled_black: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cur.pix_en |=> (out_y == BLK_Y && out_cr == BLK_C && out_cb == BLK_C))
        else $error("a_r1_disabled_black");

    // R10: horizontal blanking outside the picture is always black.
    a_r10_outside_black: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_de && !vblank) |=> (out_y == BLK_Y && out_cr == BLK_C && out_cb == BLK_C))
        else $error("a_r10_outside_black");

    // R3: solid field shows the active colour one cycle later.
    a_r3_solid_colour: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur.pix_en && mode_cur.pat_en && mode_cur.pat_solid && act_de)
        |=> (out_y == $past(cy) && out_cr == $past(ccr) && out_cb == $past(ccb)))
        else $error("a_r3_solid_colour");

endmodule

// File: tb/sim_hdtv_pattern_blank.sv
module sim_hdtv_pattern_blank;
    localparam int CLK_P = 10;

    typedef struct {
        int    y, cr, cb;
        string tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic frame_start = 0, act_de = 0, vblank = 0, dv = 0;
    logic [10:0] line_num = '0, act_line = '0;
    logic [11:0] act_col = '0;
    logic [9:0] in_y = '0, in_cr = '0, in_cb = '0;
    logic m_pix_en = 0, m_pat_en = 0, m_pat_solid = 0, m_vbi_open = 0, m_std_720p = 0, m_dv_low = 0;
    logic col_we = 0;
    logic [9:0] col_y_wr = '0, col_cr_wr = '0, col_cb_wr = '0;
    logic [9:0] out_y, out_cr, out_cb;

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    exp_t q[$];

    // bench model of active and staged settings
    bit sh_pix, sh_pat, sh_sol, sh_vbi, sh_720, sh_dvl;
    int sh_y = 940, sh_cr = 512, sh_cb = 512;
    int st_y = 940, st_cr = 512, st_cb = 512;
    // requested next mode values (applied to the pins at the next step)
    bit r_pix, r_pat, r_sol, r_vbi, r_720, r_dvl;

    hdtv_pattern_blank u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .act_de(act_de),
        .vblank(vblank), .line_num(line_num), .act_line(act_line), .act_col(act_col),
        .dv(dv), .in_y(in_y), .in_cr(in_cr), .in_cb(in_cb),
        .m_pix_en(m_pix_en), .m_pat_en(m_pat_en), .m_pat_solid(m_pat_solid),
        .m_vbi_open(m_vbi_open), .m_std_720p(m_std_720p), .m_dv_low(m_dv_low),
        .col_we(col_we), .col_y_wr(col_y_wr), .col_cr_wr(col_cr_wr), .col_cb_wr(col_cb_wr),
        .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input int ay, acr, acb, ey, ecr, ecb);
        n_tests++;
        if (ay != ey || acr != ecr || acb != ecb) begin
            n_fail++;
            $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d", tag, ay, acr, acb, ey, ecr, ecb);
        end
    endtask

    // one pixel cycle: drive pins at negedge, predict, update model
    task automatic step(input bit fs, de, vb, input int ln, al, ac, input bit v,
                        input int y, cr, cb, input bit we, input int wy, wcr, wcb, input string tag);
        exp_t e;
        bit qual, win;
        @(negedge clk);
        frame_start = fs; act_de = de; vblank = vb;
        line_num = 11'(ln); act_line = 11'(al); act_col = 12'(ac); dv = v;
        in_y = 10'(y); in_cr = 10'(cr); in_cb = 10'(cb);
        m_pix_en = r_pix; m_pat_en = r_pat; m_pat_solid = r_sol;
        m_vbi_open = r_vbi; m_std_720p = r_720; m_dv_low = r_dvl;
        col_we = we; col_y_wr = 10'(wy); col_cr_wr = 10'(wcr); col_cb_wr = 10'(wcb);
        e.y = 64; e.cr = 512; e.cb = 512; e.tag = tag;
        qual = v ^ sh_dvl;
        win = sh_720 ? (ln >= 6 && ln <= 25) : (ln >= 7 && ln <= 20);
        if (sh_pix) begin
            if (de) begin
                if (sh_pat) begin
                    if (sh_sol || (ac % 64 == 0) || (al % 64 == 0)) begin
                        e.y = sh_y; e.cr = sh_cr; e.cb = sh_cb;
                    end
                end else if (qual) begin
                    e.y = y; e.cr = cr; e.cb = cb;
                end
            end else if (vb && sh_vbi && win && qual) begin
                e.y = y; e.cr = cr; e.cb = cb;
            end
        end
        q.push_back(e);
        if (fs) begin
            sh_pix = r_pix; sh_pat = r_pat; sh_sol = r_sol;
            sh_vbi = r_vbi; sh_720 = r_720; sh_dvl = r_dvl;
            sh_y = st_y; sh_cr = st_cr; sh_cb = st_cb;
        end
        if (we) begin st_y = wy; st_cr = wcr; st_cb = wcb; end
    endtask

    task automatic set_mode(input bit p, pt, s, vo, s7, dl);
        r_pix = p; r_pat = pt; r_sol = s; r_vbi = vo; r_720 = s7; r_dvl = dl;
    endtask
    task automatic new_frame();
        step(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "frame");
    endtask
    task automatic px(input int al, ac, input bit v, input int y, cr, cb, input string tag);
        step(0, 1, 0, 100, al, ac, v, y, cr, cb, 0, 0, 0, 0, tag);
    endtask
    task automatic vbl(input int ln, input bit v, input int y, input string tag);
        step(0, 0, 1, ln, 0, 0, v, y, 300, 700, 0, 0, 0, 0, tag);
    endtask

    // monitor: compares each output against the queued prediction
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, int'(out_y), int'(out_cr), int'(out_cb), e.y, e.cr, e.cb);
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        set_mode(0, 0, 0, 0, 0, 0);
        repeat (4) @(posedge clk);
        #(CLK_P/4);
        check("R11 reset black", int'(out_y), int'(out_cr), int'(out_cb), 64, 512, 512);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #(CLK_P/4);
        check("R11 after reset", int'(out_y), int'(out_cr), int'(out_cb), 64, 512, 512);

        // R1: disabled output, pattern on, live data and blanking window
        set_mode(0, 1, 1, 1, 0, 0); new_frame();
        px(0, 0, 1, 500, 300, 700, "R1 pat on but disabled");
        set_mode(0, 0, 0, 1, 0, 0); new_frame();
        px(3, 5, 1, 500, 300, 700, "R1 live input ignored");
        vbl(10, 1, 777, "R1 vbi window ignored");

        // R2 live pass and unqualified black
        set_mode(1, 0, 0, 0, 0, 0); new_frame();
        px(1, 1, 1, 500, 300, 700, "R2 qualified passes");
        px(1, 2, 0, 501, 301, 701, "R2 unqualified black");
        px(1, 3, 1, 123, 456, 789, "R2 second pattern");

        // R8 active-low strobe
        set_mode(1, 0, 0, 0, 0, 1); new_frame();
        px(2, 1, 0, 400, 200, 600, "R8 low strobe qualifies");
        px(2, 2, 1, 400, 200, 600, "R8 high strobe rejected");

        // R5/R3 solid with reset white
        set_mode(1, 1, 1, 0, 0, 0); new_frame();
        px(7, 9, 0, 1, 2, 3, "R5 white after reset");
        px(200, 333, 1, 1, 2, 3, "R3 solid any pixel");

        // R9 colour write mid-frame does not show until frame start
        step(0, 0, 0, 100, 0, 0, 0, 0, 0, 0, 1, 500, 100, 900, "R10 hblank during write");
        px(8, 9, 1, 1, 2, 3, "R9 old colour until frame start");
        set_mode(1, 0, 0, 0, 0, 0);
        px(8, 10, 1, 1, 2, 3, "R9 mode change held mid-frame");
        set_mode(1, 1, 1, 0, 0, 0);
        // write on the frame-start edge: must wait a further frame
        step(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 1, 300, 400, 200, "frame+write");
        px(9, 9, 1, 1, 2, 3, "R3 new colour after frame start");
        new_frame();
        px(9, 9, 1, 1, 2, 3, "R9 same-edge write next frame");

        // R4 hatch
        set_mode(1, 1, 0, 0, 0, 0); new_frame();
        px(5, 0, 1, 1, 2, 3, "R4 column 0 line");
        px(5, 1, 1, 1, 2, 3, "R4 column 1 black");
        px(5, 63, 1, 1, 2, 3, "R4 column 63 black");
        px(5, 64, 1, 1, 2, 3, "R4 column 64 line");
        px(5, 65, 1, 1, 2, 3, "R4 column 65 black");
        px(64, 3, 1, 1, 2, 3, "R4 line 64 row");
        px(0, 77, 1, 1, 2, 3, "R4 line 0 row");
        px(63, 128, 1, 1, 2, 3, "R4 column 128 line");
        step(0, 0, 0, 100, 0, 0, 1, 9, 9, 9, 0, 0, 0, 0, "R10 hatch hblank black");

        // R6 1080i window
        set_mode(1, 1, 1, 1, 0, 0); new_frame();
        vbl(6, 1, 111, "R6 line 6 outside");
        vbl(7, 1, 112, "R6 line 7 inside");
        vbl(20, 1, 113, "R6 line 20 inside");
        vbl(21, 1, 114, "R6 line 21 outside");
        vbl(12, 0, 115, "R6 unqualified in window");

        // R7 720p window and closed
        set_mode(1, 1, 1, 1, 1, 0); new_frame();
        vbl(5, 1, 121, "R7 line 5 outside");
        vbl(6, 1, 122, "R7 line 6 inside");
        vbl(25, 1, 123, "R7 line 25 inside");
        vbl(26, 1, 124, "R7 line 26 outside");
        set_mode(1, 1, 1, 0, 1, 0); new_frame();
        vbl(10, 1, 125, "R7 closed line 10 black");
        vbl(6, 1, 126, "R7 closed line 6 black");

        // R10 latency: distinct consecutive values appear one cycle apart
        set_mode(1, 0, 0, 0, 0, 0); new_frame();
        px(3, 3, 1, 101, 201, 301, "R10 latency a");
        px(3, 4, 1, 102, 202, 302, "R10 latency b");
        step(0, 0, 0, 100, 0, 0, 1, 9, 9, 9, 0, 0, 0, 0, "R10 hblank live black");

        repeat (3) @(posedge clk);
        #(CLK_P/2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule